// File: doc/BRIEF.md
# Serial Configuration Write Port

This block takes configuration writes from a three-wire serial link: a bit clock, a shift/commit control line and a data line. These wires share pins with an output data bus, so the link carries configuration traffic only while a line-start qualifier is high. All four link wires arrive asynchronously. Each one passes through a two-flop synchronizer into the system clock domain, and every edge is detected on the synchronized copies.

While the commit line is low, each rising edge of the bit clock appends the data bit to a nine-bit history. When the commit line rises, the most recent nine bits form a frame. The first three bits of the frame are the register address and the last six are the value, and both go out most significant bit first. The frame is written into one of eight six-bit configuration registers. No chip-select marks the start of a frame. Whatever nine bits were shifted last are what gets committed. The registers are exposed in parallel, and a one-cycle strobe together with the address reports every commit.

Top module: `cfg_serial_port`

## Requirements
- R1: After synchronous reset, all eight registers read zero and the write strobe is low.
- R2: The data bit is captured on each rising edge of the bit clock. In a nine-bit frame, bits 8..6 (sent first) are the address and bits 5..0 are the data, most significant bit first.
- R3: While the commit line is high, bit-clock edges shift nothing. A later commit reuses the frame that was held before.
- R4: A commit updates only the addressed register. The other seven keep their values.
- R5: When more than nine bits are shifted before a commit, only the last nine count and the earlier bits are discarded.
- R6: When fewer than nine bits are shifted, the commit uses the new bits together with the older bits still held in the history.
- R7: While line-start is low, bit-clock edges shift nothing and a commit-line rising edge writes nothing.
- R8: Each commit raises the write strobe for exactly one clock cycle and presents the written address on the address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Qualifier; the link is active while high (asynchronous) |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| latch_i | input | 1 | Low: shift; rising edge: commit (asynchronous) |
| sdi_i | input | 1 | Serial data bit (asynchronous) |
| cfg_regs_o | output | 48 | Register contents; register k at bits [6k+5:6k] |
| wr_stb_o | output | 1 | One-cycle pulse per commit |
| wr_addr_o | output | 3 | Address of the register being written, valid with the strobe |

## Verification
The bench checks the frame boundary when more or fewer than nine bits arrive. A design that counts bits instead of keeping a history would drop a long frame or refuse a short one, rather than commit the last nine bits. The bench pulses the bit clock while the commit line is high. A shifter that ignores the commit line would then corrupt the held frame, and the next commit would write a different register. The bench also raises the commit line while line-start is low. A design without that gate writes a register and pulses the strobe when it should stay silent. Finally, the bench counts strobe pulses to catch a strobe stretched over several cycles or an address that does not match the register written.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 6;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int NREG    = 1 << ADDR_W;

    // Synchronized view of the link wires
    typedef struct packed {
        logic line;
        logic sck;
        logic latch;
        logic sdi;
    } link_t;

    // Appends one bit at the LSB end, dropping the oldest bit
    function automatic logic [FRAME_W-1:0] push_bit(logic [FRAME_W-1:0] hist, logic b);
        return {hist[FRAME_W-2:0], b};
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import cfgp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  link_t         lk_i,
    output logic          commit_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    localparam int FW = AW + DW;

    logic          sck_d, latch_d;
    logic [FW-1:0] hist;
    logic          sck_rise, latch_rise, shift_en, commit_en;

    assign sck_rise   = lk_i.sck & ~sck_d;
    assign latch_rise = lk_i.latch & ~latch_d;
    assign shift_en   = lk_i.line & ~lk_i.latch & sck_rise;
    assign commit_en  = lk_i.line & latch_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d    <= 1'b0;
            latch_d  <= 1'b0;
            hist     <= '0;
            commit_o <= 1'b0;
            addr_o   <= '0;
            data_o   <= '0;
        end else begin
            sck_d    <= lk_i.sck;
            latch_d  <= lk_i.latch;
            commit_o <= commit_en;
            if (shift_en) hist <= {hist[FW-2:0], lk_i.sdi};
            if (commit_en) begin
                addr_o <= hist[FW-1:DW];
                data_o <= hist[DW-1:0];
            end
        end
    end

    AST_HOLD_WHILE_LATCHED: assert property (@(posedge clk) disable iff (rst)
        lk_i.latch |=> $stable(hist)); // R3
    AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !lk_i.line |=> !commit_o); // R7
    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !lk_i.line |=> $stable(hist)); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o); // R8
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfgp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      data_i,
    output logic [(1<<AW)*DW-1:0] q_o
);
    localparam int NR = 1 << AW;

    logic [DW-1:0] mem [NR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[addr_i] <= data_i;
        end
    end

    for (genvar g = 0; g < NR; g++) begin : g_flat
        assign q_o[g*DW +: DW] = mem[g];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we_i |=> mem[$past(addr_i)] == $past(data_i)); // R4
    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(q_o)); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> q_o == '0); // R1
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfgp_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int SYNC_ST = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   line_start_i,
    input  logic                   sck_i,
    input  logic                   latch_i,
    input  logic                   sdi_i,
    output logic [(1<<AW)*DW-1:0]  cfg_regs_o,
    output logic                   wr_stb_o,
    output logic [AW-1:0]          wr_addr_o
);
    localparam int LW = $bits(link_t);

    link_t         raw, lk;
    logic [LW-1:0] lk_bits;
    logic          commit;
    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_data;

    assign raw = '{line: line_start_i, sck: sck_i, latch: latch_i, sdi: sdi_i};

    cfg_sync #(.W(LW), .STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (lk_bits)
    );

    assign lk = link_t'(lk_bits);

    cfg_shifter #(.AW(AW), .DW(DW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .lk_i     (lk),
        .commit_o (commit),
        .addr_o   (c_addr),
        .data_o   (c_data)
    );

    cfg_regbank #(.AW(AW), .DW(DW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we_i   (commit),
        .addr_i (c_addr),
        .data_i (c_data),
        .q_o    (cfg_regs_o)
    );

    assign wr_stb_o  = commit;
    assign wr_addr_o = c_addr;

    AST_STB_LOW_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !wr_stb_o); // R1
endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
    localparam int AW = 3;
    localparam int DW = 6;
    localparam int NR = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0, sck = 1'b0, latch = 1'b0, sdi = 1'b0;
    logic [NR*DW-1:0] regs;
    logic wr_stb;
    logic [AW-1:0] wr_addr;

    int n_chk = 0, n_fail = 0;
    int stb_cnt = 0;
    logic [AW-1:0] last_addr = '0;
    logic [AW+DW-1:0] model = '0;
    logic [DW-1:0] exp_r [NR];
    int exp_stb = 0;
    logic [AW-1:0] exp_addr = '0;

    always #5 clk = ~clk;

    cfg_serial_port u0 (
        .clk(clk), .rst(rst), .line_start_i(line_start), .sck_i(sck),
        .latch_i(latch), .sdi_i(sdi), .cfg_regs_o(regs),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr)
    );

    always @(posedge clk) begin
        if (!rst && wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr;
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < NR; i++)
            chk(req, 32'(regs[i*DW +: DW]), 32'(exp_r[i]));
        chk(req, 32'(stb_cnt), 32'(exp_stb));
        if (exp_stb > 0) chk(req, 32'(last_addr), 32'(exp_addr));
    endtask

    task automatic send_bit(logic b);
        sdi = b; settle();
        sck = 1'b1; settle();
        sck = 1'b0; settle();
        if (line_start && !latch) model = {model[AW+DW-2:0], b};
    endtask

    task automatic send_bits(logic [15:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic latch_up();
        latch = 1'b1; settle();
        if (line_start) begin
            exp_r[model[AW+DW-1:DW]] = model[DW-1:0];
            exp_addr = model[AW+DW-1:DW];
            exp_stb++;
        end
    endtask

    task automatic latch_down();
        latch = 1'b0; settle();
    endtask

    task automatic write_frame(logic [AW-1:0] a, logic [DW-1:0] d);
        send_bits(16'({a, d}), AW + DW);
        latch_up();
        latch_down();
    endtask

    // R1
    task automatic t_reset();
        check_regs("R1");
        chk("R1", 32'(wr_stb), 32'd0);
    endtask

    // R2 R4 R8: plain frames, several patterns
    task automatic t_basic();
        write_frame(3'd5, 6'h2B); check_regs("R2");
        write_frame(3'd0, 6'h3F); check_regs("R4");
        write_frame(3'd7, 6'h01); check_regs("R8");
        write_frame(3'd5, 6'h14); check_regs("R4");
    endtask

    // R3: bit-clock edges while latched must not alter the held frame
    task automatic t_latched();
        send_bits(16'({3'd2, 6'h15}), 9);
        latch_up();
        send_bits(16'({3'd3, 6'h3C}), 9);
        latch_down();
        latch_up();
        latch_down();
        check_regs("R3");
        chk("R3", 32'(regs[3*DW +: DW]), 32'd0);
    endtask

    // R5: extra leading bits dropped
    task automatic t_long();
        send_bits(16'b111, 3);
        write_frame(3'd4, 6'h0A);
        check_regs("R5");
        chk("R5", 32'(regs[4*DW +: DW]), 32'h0A);
    endtask

    // R6: short frame mixes with stale history (prev frame 100_001010)
    task automatic t_short();
        send_bits(16'b110, 3);
        latch_up(); latch_down();
        check_regs("R6");
        chk("R6", 32'(regs[1*DW +: DW]), 32'h16);
    endtask

    // R7: line-start low blocks shifting and committing
    task automatic t_idle();
        logic [AW+DW-1:0] saved;
        saved = model;
        line_start = 1'b0; settle();
        send_bits(16'({3'd6, 6'h33}), 9);
        latch_up(); latch_down();
        check_regs("R7");
        chk("R7", 32'(regs[6*DW +: DW]), 32'd0);
        line_start = 1'b1; settle();
        latch_up(); latch_down();
        check_regs("R7");
        chk("R7", 32'(model), 32'(saved));
    endtask

    // R8: strobe width counted in cycles
    task automatic t_strobe_width();
        int hi;
        hi = 0;
        send_bits(16'({3'd6, 6'h2A}), 9);
        latch = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (wr_stb) hi++;
        end
        exp_r[6] = 6'h2A; exp_addr = 3'd6; exp_stb++;
        model = {3'd6, 6'h2A};
        latch_down();
        chk("R8", 32'(hi), 32'd1);
        check_regs("R8");
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < NR; i++) exp_r[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        line_start = 1'b1; settle();
        t_basic();
        t_latched();
        t_long();
        t_short();
        t_idle();
        t_strobe_width();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule